// File: doc/BRIEF.md
# Shift-Add Rotation Multiply-Accumulate Element

This element is one link in a chain that performs convolution without a hardware multiplier. A kernel weight is not held as a number. It is held as an 8-bit code of rotation directions, which stands for the sine of an angle. The element rotates the vector (pixel, 0) through that angle using only shifts and additions. It scales the resulting vertical component by a fixed shift-add reciprocal gain, which gives approximately pixel × sin(θ). It then adds this product to a partial sum taken from the element before it and presents the new sum to the next element.

A start strobe captures the pixel, the code and the incoming partial sum together. The rotation then runs for exactly three clock cycles:

- The coarse pre-rotation is applied as the operands are loaded.
- Each cycle after that applies two micro-rotations.

Completion is marked by a single-cycle done pulse. The accumulated sum is held at the output until the next accepted start.

Top module: `rotMac`

## Requirements
- R1: When the element is idle, a high `start` at a rising clock edge captures `pixel`, `code` and `psumIn`. Later changes on these three inputs have no effect on the result of that operation.
- R2: A synchronous high `rst` clears all state. Done is low after the reset edge, and `psumOut` is 0.
- R3: `done` is high for exactly one cycle. It rises in the third cycle after the edge that accepted `start`, so it is sampled high at the fourth edge.
- R4: A `start` that arrives while an operation is in progress is ignored. This includes a `start` at the edge that completes the operation. A new operation is accepted only from the edge that follows the done cycle.
- R5: The pixel is unsigned and enters the rotation as x = pixel·2^6, y = 0. Code bit 7 = 0 skips the coarse stage. Bit 7 = 1 with bit 6 = 0 rotates by +90°, giving (x, y) → (−y, x). Bit 7 = 1 with bit 6 = 1 rotates by +atan(1/2), giving x' = x − (y>>>1) and y' = y + (x>>>1).
- R6: Six micro-rotations follow, with i = 1 to 6 in order, and code bit 6−i sets the direction of step i. A bit of 1 gives x' = x − (y>>>i) and y' = y + (x>>>i). A bit of 0 gives x' = x + (y>>>i) and y' = y − (x>>>i). All shifts are arithmetic.
- R7: The product is the final y multiplied by a reciprocal gain and then shifted right arithmetically by 6. When code bits 7 and 6 are both 1, the scaled value is (y>>>1)+(y>>>2)+(y>>>6)+(y>>>9)+(y>>>11). In every other case it is y−(y>>>3)−(y>>>6)−(y>>>11).
- R8: During the done cycle, `psumOut` equals the captured `psumIn` plus the product, as a 20-bit signed value.
- R9: After `done`, `psumOut` keeps its value until the next operation is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| pixel | input | 8 | Unsigned pixel value |
| code | input | 8 | Rotation-direction code standing for the weight |
| psumIn | input | 20 | Signed partial sum from the preceding element |
| psumOut | output | 20 | Signed partial sum passed to the next element |
| done | output | 1 | One-cycle completion pulse |

## Verification
Faults in different parts of the element show at the ports in different ways:

- **Sequencing counter:** a wrong value moves or repeats the done pulse within the four cycles after a start, so the fault is visible before the next operation can begin.
- **Rotation state:** a fault in the x/y state, a wrong shift distance or a misread direction bit changes `psumOut` in that same done cycle. The bench compares every code against an integer model of the rotation equations.
- **Operand capture:** a lost or wrongly held operand reveals itself only when the inputs are disturbed during the busy cycles. The bench therefore scrambles all inputs while the element is working and compares the result at the next done.

// File: rtl/rotMacPkg.sv
package rotMacPkg;
  parameter int PIX_W      = 8;
  parameter int CODE_W     = 8;
  parameter int ACC_W      = 20;
  parameter int REG_W      = 16;
  parameter int FRAC       = 6;
  parameter int PER_CYCLE  = 2;
  parameter int NUM_MICRO  = 6;

  localparam int NUM_PAIRS = NUM_MICRO / PER_CYCLE;
  localparam int PAIR_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int SEL_BIT   = CODE_W - 1;
  localparam int KIND_BIT  = CODE_W - 2;
  localparam int MICRO_TOP = NUM_MICRO - 1;

  typedef struct packed {
    logic              load;
    logic              advance;
    logic [PAIR_W-1:0] pairIdx;
  } rotStrobe_t;
endpackage

// File: rtl/rotMacCtrl.sv
module rotMacCtrl
  import rotMacPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output rotStrobe_t strobe,
  output logic       done
);
  logic              busy;
  logic [PAIR_W-1:0] pairCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pairCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (pairCnt == PAIR_W'(NUM_PAIRS - 1)) begin
          busy    <= 1'b0;
          pairCnt <= '0;
          done    <= 1'b1;
        end else begin
          pairCnt <= pairCnt + 1'b1;
        end
      end else if (start) begin
        busy    <= 1'b1;
        pairCnt <= '0;
      end
    end
  end

  assign strobe.load    = !busy && start;
  assign strobe.advance = busy;
  assign strobe.pairIdx = pairCnt;
endmodule

// File: rtl/rotMacPath.sv
module rotMacPath
  import rotMacPkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  rotStrobe_t               strobe,
  input  logic [PIX_W-1:0]         pixel,
  input  logic [CODE_W-1:0]        code,
  input  logic signed [ACC_W-1:0]  psumIn,
  output logic signed [ACC_W-1:0]  psumOut
);
  localparam int PAD  = REG_W - PIX_W - FRAC;
  localparam int SC_W = REG_W + 2;

  logic signed [REG_W-1:0]  xR, yR;
  logic [CODE_W-1:0]        codeR;
  logic signed [ACC_W-1:0]  accR;

  // coarse pre-rotation applied to the freshly loaded operands
  logic signed [REG_W-1:0] x0, xC, yC;
  assign x0 = {{PAD{1'b0}}, pixel, {FRAC{1'b0}}};

  always_comb begin
    xC = x0;
    yC = '0;
    if (code[SEL_BIT]) begin
      if (code[KIND_BIT]) begin
        xC = x0;
        yC = x0 >>> 1;
      end else begin
        xC = '0;
        yC = x0;
      end
    end
  end

  // micro-rotations for the current cycle
  logic signed [REG_W-1:0] xStep [PER_CYCLE+1];
  logic signed [REG_W-1:0] yStep [PER_CYCLE+1];
  assign xStep[0] = xR;
  assign yStep[0] = yR;

  for (genvar k = 0; k < PER_CYCLE; k++) begin : g_micro
    logic [3:0] sh;
    logic       dirPos;
    assign sh     = 4'((int'(strobe.pairIdx) * PER_CYCLE) + k + 1);
    assign dirPos = codeR[MICRO_TOP - (int'(sh) - 1)];
    always_comb begin
      if (dirPos) begin
        xStep[k+1] = xStep[k] - (yStep[k] >>> sh);
        yStep[k+1] = yStep[k] + (xStep[k] >>> sh);
      end else begin
        xStep[k+1] = xStep[k] + (yStep[k] >>> sh);
        yStep[k+1] = yStep[k] - (xStep[k] >>> sh);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xR    <= '0;
      yR    <= '0;
      codeR <= '0;
      accR  <= '0;
    end else if (strobe.load) begin
      xR    <= xC;
      yR    <= yC;
      codeR <= code;
      accR  <= psumIn;
    end else if (strobe.advance) begin
      xR <= xStep[PER_CYCLE];
      yR <= yStep[PER_CYCLE];
    end
  end

  // reciprocal gain correction, chosen by whether the atan(1/2) stage ran
  logic signed [SC_W-1:0] yW, scaled, product;
  logic                   extraGain;
  assign yW        = SC_W'(yR);
  assign extraGain = codeR[SEL_BIT] & codeR[KIND_BIT];

  always_comb begin
    if (extraGain)
      scaled = (yW >>> 1) + (yW >>> 2) + (yW >>> 6) + (yW >>> 9) + (yW >>> 11);
    else
      scaled = yW - (yW >>> 3) - (yW >>> 6) - (yW >>> 11);
    product = scaled >>> FRAC;
  end

  assign psumOut = accR + ACC_W'(product);
endmodule

// File: rtl/rotMac.sv
module rotMac
  import rotMacPkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [7:0]              pixel,
  input  logic [7:0]              code,
  input  logic signed [19:0]      psumIn,
  output logic signed [19:0]      psumOut,
  output logic                    done
);
  rotStrobe_t strobe;

  rotMacCtrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  rotMacPath i_path (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .pixel   (pixel),
    .code    (code),
    .psumIn  (psumIn),
    .psumOut (psumOut)
  );
endmodule

// File: rtl/rotMacChk.sv
module rotMacChk (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic signed [19:0] psumOut,
  input logic               done
);
  // R3: completion pulse lasts one cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: completion follows an accepted start by the fixed latency
  p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 4));

  // R4: no new completion can come from a start seen while busy
  p_done_gap_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!$past(done, 1) && !$past(done, 2) && !$past(done, 3)));

  // R2: reset clears the completion flag and the output sum
  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (!done && psumOut == 20'sd0));
endmodule

bind rotMac rotMacChk u_rotMacChk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .psumOut (psumOut),
  .done    (done)
);

// File: tb/test_rotMac.sv
`timescale 1ns/1ps
module test_rotMac;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [7:0]         pixel = '0;
  logic [7:0]         code = '0;
  logic signed [19:0] psumIn = '0;
  logic signed [19:0] psumOut;
  logic               done;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rotMac i_rotMac (
    .clk(clk), .rst(rst), .start(start), .pixel(pixel),
    .code(code), .psumIn(psumIn), .psumOut(psumOut), .done(done)
  );

  // integer model of the rotation equations in R5, R6 and R7
  function automatic int expProduct(int pix, logic [7:0] c);
    int x, y, nx, ny, s;
    x = pix * 64;
    y = 0;
    if (c[7]) begin
      if (c[6]) begin nx = x - (y >>> 1); ny = y + (x >>> 1); end
      else      begin nx = -y;            ny = x;             end
      x = nx; y = ny;
    end
    for (int i = 1; i <= 6; i++) begin
      if (c[6-i]) begin nx = x - (y >>> i); ny = y + (x >>> i); end
      else        begin nx = x + (y >>> i); ny = y - (x >>> i); end
      x = nx; y = ny;
    end
    if (c[7] && c[6]) s = (y >>> 1) + (y >>> 2) + (y >>> 6) + (y >>> 9) + (y >>> 11);
    else              s = y - (y >>> 3) - (y >>> 6) - (y >>> 11);
    return s >>> 6;
  endfunction

  // cycle model: remaining busy cycles, expected done, expected sum
  int cnt = 0;
  logic expDone = 1'b0;
  int expVal = 0;

  always @(posedge clk) begin
    if (rst) begin
      cnt = 0; expDone = 1'b0; expVal = 0;
    end else begin
      expDone = 1'b0;
      if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) expDone = 1'b1;
      end else if (start) begin
        cnt = 3;
        expVal = int'(psumIn) + expProduct(int'(pixel), code);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      check("R2 done in reset", int'(done), 0);
    end else begin
      check("R3/R4 done timing", int'(done), int'(expDone));
      if (expDone)
        check("R1/R5/R6/R7/R8 sum at done", int'(psumOut), expVal);
      else if (cnt == 0)
        check("R2/R9 held sum while idle", int'(psumOut), expVal);
    end
  end

  task automatic runOp(logic [7:0] p, logic [7:0] c, int ps, bit holdStart);
    @(posedge clk); #1;
    start = 1'b1; pixel = p; code = c; psumIn = 20'(ps);
    @(posedge clk); #1;
    // R1/R4: disturb every input while the element is busy
    start = holdStart; pixel = ~p; code = ~c; psumIn = 20'(-ps - 7);
    repeat (3) @(posedge clk);
    #1 start = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  logic [7:0] codes [12] = '{8'h00, 8'hFF, 8'h80, 8'hC0, 8'hBF, 8'h55,
                             8'hAA, 8'hE3, 8'h3F, 8'hA0, 8'hDA, 8'h7E};
  logic [7:0] pixels [5] = '{8'd0, 8'd255, 8'd128, 8'd1, 8'd77};
  int psums [4] = '{0, -5000, 300000, -524000};

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R5/R6/R7: every code against several pixels and partial sums
    foreach (codes[ci]) begin
      foreach (pixels[pi]) begin
        runOp(pixels[pi], codes[ci], psums[(ci + pi) % 4], ((ci + pi) % 2) == 1);
      end
    end
    // R4: start held high across the completing edge
    runOp(8'd200, 8'hC5, 1234, 1'b1);
    // R2: reset in the middle of an operation
    @(posedge clk); #1 start = 1'b1; pixel = 8'd90; code = 8'h9C; psumIn = 20'sd55;
    @(posedge clk); #1 start = 1'b0; rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    repeat (5) @(posedge clk);
    runOp(8'd33, 8'h81, -77, 1'b0);
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule